// File: doc/BRIEF.md
# General-Purpose Port Register Block with Power-Mode Strobes

This block is an 8-bit memory-mapped I/O port for a small controller. The low six bits are ordinary bidirectional pins. Each has its own direction bit and its own value bit, and software writes both. The seventh pin can only be an input. The eighth pin always drives out the oscillator clock. Neither of these two pins needs a register bit, so their bit positions carry control functions instead. One data bit asks the power manager for halt. Another data bit asks for idle. A configuration bit chooses which edge of the serial shift clock the serial engine uses.

A CPU reaches the block through a simple register bus. The bus has an address, a write strobe and write data, plus a read-data output that follows the address combinationally. There are three addresses:

- a value register;
- a direction register;
- a pin-sense address, which returns the synchronized live pin levels.

Halt and idle requests leave the block as one-cycle pulses. The serial-clock phase select leaves it as a steady level. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `gpio_ctl_port`

## Requirements
- R1: After reset, the value and direction registers are zero. Every pin 0..5 is an input (pin_oe[5:0]=0) with its pull-up off. halt_req, idle_req and sk_alt_phase are low.
- R2: Writing the direction register (address 1) sets pin_oe[i] = wdata[i] for i in 0..5, starting the cycle after the write strobe. A 1 means output. The outputs hold until the next write to that address.
- R3: pin_out[i] equals value bit i for i in 0..5. pin_pu[i] is high only when value bit i is 1 and pin i is an input.
- R4: Pin 6 is never driven (pin_oe[6]=0, pin_out[6]=0). Pin 7 is always driven (pin_oe[7]=1), and pin_out[7] follows osc_clk.
- R5: A read of the value register (address 0) or the direction register (address 1) returns the stored bits 5..0, with bits 7 and 6 always 0.
- R6: Writing the value register with wdata[7]=1 raises halt_req for exactly the one cycle after the write. Nothing is stored, so the next request needs another write.
- R7: Writing the value register with wdata[6]=1 and wdata[7]=0 raises idle_req for one cycle. When both bits are 1, only halt_req pulses.
- R8: Writing the direction register sets sk_alt_phase to wdata[6]. The level holds across writes to the value register.
- R9: A read of the pin-sense address (address 2) returns {0, pin_in[6:0]} as sampled through a two-flop synchronizer. A pin change at the inputs shows up two clock edges later.
- R10: Unmapped addresses read as zero. A write to the pin-sense address or to an unmapped address changes no register, pin output or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| osc_clk | input | 1 | Oscillator clock forwarded to pin 7 |
| pin_in | input | 7 | Pad input levels for pins 0..6 |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| pin_pu | output | 6 | Weak pull-up enables for pins 0..5 |
| halt_req | output | 1 | One-cycle halt request pulse |
| idle_req | output | 1 | One-cycle idle request pulse |
| sk_alt_phase | output | 1 | Alternate serial clock phase select |

## Verification
A register write lands on the clock edge where bus_we is high. The new values on pin_oe, pin_out, pin_pu and sk_alt_phase, and on register read-back, are due half a cycle after that edge. halt_req and idle_req are high only in the cycle between that edge and the next one. A pin_in change reaches the pin-sense read after exactly two edges.

The bench drives every input on the falling edge and samples on the following falling edge. It checks the old value after one edge and the new value after two, so an extra or a missing register stage shows up as a mismatch.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  localparam int REG_W     = 8;
  localparam int HALT_BIT  = 7;
  localparam int IDLE_BIT  = 6;
  localparam int SKALT_BIT = 6;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_IDLE = 2'd1,
    PM_HALT = 2'd2
  } pm_req_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctl_pkg::*;
#(
  parameter int IO_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sel_val,
  input  logic             sel_dir,
  input  logic [REG_W-1:0] wdata,
  output logic [IO_N-1:0]  val_q,
  output logic [IO_N-1:0]  dir_q,
  output logic             sk_alt_q,
  output logic             halt_pulse,
  output logic             idle_pulse
);

  logic            val_en;
  logic            dir_en;
  logic [IO_N-1:0] val_d;
  logic [IO_N-1:0] dir_d;
  logic            sk_alt_d;
  pm_req_e         pm_d;
  pm_req_e         pm_q;

  assign val_en = wr_en & sel_val;
  assign dir_en = wr_en & sel_dir;

  always_comb begin
    val_d    = wdata[IO_N-1:0];
    dir_d    = wdata[IO_N-1:0];
    sk_alt_d = wdata[SKALT_BIT];
    pm_d     = PM_NONE;
    if (val_en) begin
      if (wdata[HALT_BIT]) begin
        pm_d = PM_HALT;
      end else if (wdata[IDLE_BIT]) begin
        pm_d = PM_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q    <= '0;
      dir_q    <= '0;
      sk_alt_q <= 1'b0;
      pm_q     <= PM_NONE;
    end else begin
      if (val_en) begin
        val_q <= val_d;
      end
      if (dir_en) begin
        dir_q    <= dir_d;
        sk_alt_q <= sk_alt_d;
      end
      pm_q <= pm_d;
    end
  end

  assign halt_pulse = (pm_q == PM_HALT);
  assign idle_pulse = (pm_q == PM_IDLE);

  // R6: a halt pulse only follows a value write carrying the halt bit
  a_r6_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> $past(val_en && wdata[HALT_BIT]));

  // R7: an idle pulse only follows an idle-only value write
  a_r7_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> $past(val_en && wdata[IDLE_BIT] && !wdata[HALT_BIT]));

  // R2: direction bits hold when no direction write happens
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |=> $stable(dir_q));

  // R8: phase select holds across cycles without a direction write
  a_r8_sk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |=> $stable(sk_alt_q));

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int IO_N = 6
) (
  input  logic            osc_clk,
  input  logic [IO_N-1:0] val_q,
  input  logic [IO_N-1:0] dir_q,
  output logic [IO_N+1:0] pin_out,
  output logic [IO_N+1:0] pin_oe,
  output logic [IO_N-1:0] pin_pu
);

  localparam int IN_IDX = IO_N;
  localparam int CK_IDX = IO_N + 1;

  generate
    for (genvar i = 0; i < IO_N; i++) begin : g_io
      assign pin_out[i] = val_q[i];
      assign pin_oe[i]  = dir_q[i];
      assign pin_pu[i]  = val_q[i] & ~dir_q[i];
    end
  endgenerate

  assign pin_out[IN_IDX] = 1'b0;
  assign pin_oe[IN_IDX]  = 1'b0;
  assign pin_out[CK_IDX] = osc_clk;
  assign pin_oe[CK_IDX]  = 1'b1;

endmodule

// File: rtl/gpio_ctl_port.sv
module gpio_ctl_port
  import gpio_ctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int IO_N        = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int ADDR_VAL    = 0,
  parameter int ADDR_DIR    = 1,
  parameter int ADDR_SENSE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_clk,
  input  logic [6:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe,
  output logic [5:0]        pin_pu,
  output logic              halt_req,
  output logic              idle_req,
  output logic              sk_alt_phase
);

  localparam int PORT_W  = IO_N + 2;
  localparam int SENSE_W = IO_N + 1;
  localparam int PAD_W   = REG_W - IO_N;
  localparam int SPAD_W  = REG_W - SENSE_W;

  logic               rst_i_n;
  logic               sel_val;
  logic               sel_dir;
  logic               sel_sense;
  logic [IO_N-1:0]    val_q;
  logic [IO_N-1:0]    dir_q;
  logic [SENSE_W-1:0] sense_sync;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign sel_val   = (bus_addr == ADDR_W'(ADDR_VAL));
  assign sel_dir   = (bus_addr == ADDR_W'(ADDR_DIR));
  assign sel_sense = (bus_addr == ADDR_W'(ADDR_SENSE));

  gpio_regs #(.IO_N(IO_N)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (bus_we),
    .sel_val    (sel_val),
    .sel_dir    (sel_dir),
    .wdata      (bus_wdata),
    .val_q      (val_q),
    .dir_q      (dir_q),
    .sk_alt_q   (sk_alt_phase),
    .halt_pulse (halt_req),
    .idle_pulse (idle_req)
  );

  gpio_in_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in (pin_in),
    .sync_out (sense_sync)
  );

  gpio_pinmux #(.IO_N(IO_N)) u_mux (
    .osc_clk (osc_clk),
    .val_q   (val_q),
    .dir_q   (dir_q),
    .pin_out (pin_out[PORT_W-1:0]),
    .pin_oe  (pin_oe[PORT_W-1:0]),
    .pin_pu  (pin_pu)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_val) begin
      bus_rdata = {{PAD_W{1'b0}}, val_q};
    end else if (sel_dir) begin
      bus_rdata = {{PAD_W{1'b0}}, dir_q};
    end else if (sel_sense) begin
      bus_rdata = {{SPAD_W{1'b0}}, sense_sync};
    end
  end

  // R5: the control bit positions never read back on either register
  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_val || sel_dir) |-> (bus_rdata[7:6] == 2'b00));

  // R10: a write to the sense address leaves pads and requests untouched
  a_r10_sense_write_inert: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && sel_sense) |=> ($stable(pin_oe) && $stable(pin_out[IO_N-1:0])
                               && !halt_req && !idle_req));

  // R2: pad directions move only after a direction write
  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(bus_we && sel_dir) |=> $stable(pin_oe[IO_N-1:0]));

endmodule

// File: tb/gpio_ctl_port_bench.sv
module gpio_ctl_port_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       osc_clk;
  logic [6:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [5:0] pin_pu;
  logic       halt_req;
  logic       idle_req;
  logic       sk_alt_phase;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // {dir write, value write, expected oe[5:0], expected pu[5:0], expected phase}
  localparam logic [28:0] VECS [0:5] = '{
    {8'h3F, 8'h2A, 6'h3F, 6'h00, 1'b0},
    {8'h00, 8'h15, 6'h00, 6'h15, 1'b0},
    {8'h0F, 8'h33, 6'h0F, 6'h30, 1'b0},
    {8'hF0, 8'h3C, 6'h30, 6'h0C, 1'b1},
    {8'h41, 8'h00, 6'h01, 6'h00, 1'b1},
    {8'h96, 8'h0F, 6'h16, 6'h09, 1'b0}
  };

  gpio_ctl_port u_gpio_ctl_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .osc_clk      (osc_clk),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .pin_pu       (pin_pu),
    .halt_req     (halt_req),
    .idle_req     (idle_req),
    .sk_alt_phase (sk_alt_phase)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    osc_clk   = 1'b0;
    pin_in    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h80);
    chk("R1 pu", pin_pu, 6'h00);
    chk("R1 req", {halt_req, idle_req, sk_alt_phase}, 3'b000);
    rd(4'd0, r); chk("R1 val read", r, 8'h00);
    rd(4'd1, r); chk("R1 dir read", r, 8'h00);

    // R2 R3 R5 R8 table walk
    for (int k = 0; k < 6; k++) begin
      logic [28:0] v;
      v = VECS[k];
      wr(4'd1, v[28:21]);
      wr(4'd0, v[20:13]);
      chk("R2 oe", pin_oe, {2'b10, v[12:7]});
      chk("R3 out", pin_out[5:0], v[18:13]);
      chk("R3 pu", pin_pu, v[6:1]);
      chk("R8 phase", sk_alt_phase, v[0]);
      rd(4'd0, r); chk("R5 val read", r, {2'b00, v[18:13]});
      rd(4'd1, r); chk("R5 dir read", r, {2'b00, v[26:21]});
    end

    // R6 halt pulse, one cycle, not stored
    wr(4'd0, 8'h80);
    chk("R6 halt high", {halt_req, idle_req}, 2'b10);
    chk("R8 phase kept", sk_alt_phase, 1'b0);
    @(negedge clk);
    chk("R6 halt drops", {halt_req, idle_req}, 2'b00);
    rd(4'd0, r); chk("R6 R5 val read", r, 8'h00);

    // R7 idle pulse and halt priority
    wr(4'd0, 8'h40);
    chk("R7 idle high", {halt_req, idle_req}, 2'b01);
    @(negedge clk);
    chk("R7 idle drops", {halt_req, idle_req}, 2'b00);
    wr(4'd0, 8'hC5);
    chk("R7 both set", {halt_req, idle_req}, 2'b10);
    rd(4'd0, r); chk("R7 R5 val read", r, 8'h05);

    // R8 phase set then held across value writes
    wr(4'd1, 8'h40);
    chk("R8 phase set", sk_alt_phase, 1'b1);
    rd(4'd1, r); chk("R8 R5 dir read", r, 8'h00);
    wr(4'd0, 8'h3F);
    chk("R8 phase hold", sk_alt_phase, 1'b1);

    // R4 fixed pins
    osc_clk = 1'b1; #1;
    chk("R4 ck high", {pin_oe[7:6], pin_out[7:6]}, 4'b1010);
    osc_clk = 1'b0; #1;
    chk("R4 ck low", {pin_oe[7:6], pin_out[7:6]}, 4'b1000);

    // R9 two-edge synchronizer
    rd(4'd2, r); chk("R9 sense idle", r, 8'h00);
    @(negedge clk);
    pin_in = 7'h5A;
    @(negedge clk);
    rd(4'd2, r); chk("R9 after one edge", r, 8'h00);
    @(negedge clk);
    rd(4'd2, r); chk("R9 after two edges", r, 8'h5A);
    pin_in = 7'h7F;
    repeat (2) @(negedge clk);
    rd(4'd2, r); chk("R9 all ones", r, 8'h7F);

    // R10 unmapped reads and inert writes
    rd(4'd3, r);  chk("R10 unmapped read", r, 8'h00);
    rd(4'd15, r); chk("R10 top read", r, 8'h00);
    wr(4'd2, 8'hC0);
    chk("R10 sense write", {pin_oe, pin_out[5:0], halt_req, idle_req}, {8'h80, 6'h3F, 2'b00});
    wr(4'd9, 8'hFF);
    chk("R10 unmapped write", {pin_oe, pin_pu, halt_req, idle_req}, {8'h80, 6'h3F, 2'b00});
    rd(4'd0, r); chk("R10 val kept", r, 8'h3F);
    rd(4'd1, r); chk("R10 dir kept", r, 8'h00);

    // R1 reset again clears everything
    wr(4'd1, 8'h7F);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {pin_oe, pin_pu, sk_alt_phase}, {8'h80, 6'h00, 1'b0});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd0, r); chk("R1 val after reset", r, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule